// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Engine

This block models a synchronous static RAM on a single clock. It accepts a fresh read or write on every clock edge and never needs an idle cycle when the traffic switches between writing and reading. A write command gives its address and control at one edge, and the matching data arrives two active edges later. The bus therefore carries data in one direction or the other on every cycle. Read data is registered and reaches the output one active edge after its command.

The data bus is split into an input, an output and an output-drive flag. Each byte lane holds eight data bits and one parity bit, and every lane has its own active-low write select. A clock enable freezes the whole block. A load/advance strobe steps through a four-beat linear burst without a new address. A read whose address matches a write still in flight returns the byte-merged pending data.

Top module: `psram_top`

## Requirements
- R1: A command is taken at an edge with `cke_n` low and `ld_n` low. Write when `we_n` is low, read when it is high. It is an access only if `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. Any other chip-enable combination is a deselect, and the block writes nothing.
- R2: Read data for a command at edge N appears on `dout` after active edge N+1, and `dq_oe` is high in that cycle when `oe_n` is low. A new command may be issued at edge N+1.
- R3: For a write command at active edge N, `din` is stored at active edge N+2. Stall edges are not counted.
- R4: Lane i is `din` bits [9i+8:9i], eight data bits plus one parity bit. It is written only when `bw_n[i]` was low with the write command. Unselected lanes keep their contents, and `bw_n`=2'b11 writes nothing.
- R5: An edge with `cke_n` high changes no state. It performs no write and leaves `dout` unchanged.
- R6: `dq_oe` is low during the data phase of a write, even when `oe_n` is low.
- R7: Deselect is pipelined. `dq_oe` stays driven for one more cycle after a deselecting edge and then drops, and it stays low while deselected. An advance while deselected keeps the block deselected.
- R8: `oe_n` gates `dq_oe` without a clock. A read issued with `oe_n` high still runs as a dummy read with the bus undriven.
- R9: A read whose address matches the write in its data phase returns the lanes being written from `din` and the other lanes from the array.
- R10: `ld_n` high advances the low two address bits with linear wrap (…2,3,0,1). It keeps the read/write type of the loaded burst and ignores `we_n` and the chip enables. `bw_n` is sampled again on each beat.
- R11: Synchronous reset `rst` leaves the block deselected: `dq_oe`=0, `dout`=0, and no write from before the reset completes afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Clock enable, active low |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| ld_n | input | 1 | Low loads a new command, high advances the burst |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data bus |
| dout | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | High when the block drives the bus |

## Verification
The bench fills every word and reads it back while alternating reads and writes on each cycle. A design that took write data one edge early or late would store data shifted by one address. It reads a word while that word's masked write is in its data phase. A design without forwarding would return the old contents, and one that forwarded the whole word would corrupt the unselected lane. Stall edges are placed between a write command and its data, with junk on `din`. A block that counted stalled edges would capture the junk. A reset arrives with a write in flight, so a pipeline that did not clear would still commit it. The bench also runs wrapped bursts that change lane masks between beats, with deselect on the chip enables. A burst that reloaded the type, or honoured the chip enables during an advance, would lose beats.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic logic chip_on(input logic ca_n, input logic cb, input logic cc_n);
        return (!ca_n) && cb && (!cc_n);
    endfunction

    function automatic op_e pick_op(input logic on, input logic wr_n);
        if (!on)  return OP_IDLE;
        if (wr_n) return OP_READ;
        return OP_WRITE;
    endfunction

endpackage

// File: rtl/psram_cmd.sv
module psram_cmd
    import psram_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int LANES   = 2,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_n,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              ld_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_be
);
    localparam logic [BURST_W-1:0] STEP = {{(BURST_W-1){1'b0}}, 1'b1};

    op_e               nxt_op;
    logic [ADDR_W-1:0] nxt_addr;

    always_comb begin
        nxt_addr = s1_addr;
        if (!ld_n) begin
            nxt_op   = pick_op(chip_on(ce_a_n, ce_b, ce_c_n), we_n);
            nxt_addr = addr;
        end else begin
            nxt_op = s1_op;
            nxt_addr[BURST_W-1:0] = s1_addr[BURST_W-1:0] + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_op   <= OP_IDLE;
            s1_addr <= '0;
            s1_be   <= '0;
        end else if (!cke_n) begin
            s1_op   <= nxt_op;
            s1_addr <= nxt_addr;
            s1_be   <= ~bw_n;
        end
    end
endmodule

// File: rtl/psram_wpipe.sv
module psram_wpipe
    import psram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_n,
    input  op_e               s1_op,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic [LANES-1:0]  s1_be,
    output logic              wr_phase,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_be
);
    op_e s2_op;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_op   <= OP_IDLE;
            wr_addr <= '0;
            wr_be   <= '0;
        end else if (!cke_n) begin
            s2_op   <= s1_op;
            wr_addr <= s1_addr;
            wr_be   <= s1_be;
        end
    end

    assign wr_phase = (s2_op == OP_WRITE);
    assign wr_en    = wr_phase && !cke_n;
endmodule

// File: rtl/psram_array.sv
module psram_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic                    fwd_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic hit;
    assign hit = fwd_en && (wr_addr == rd_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[l])
                cells[wr_addr] <= din[l*LANE_W +: LANE_W];
        end

        assign rd_data[l*LANE_W +: LANE_W] =
            (hit && wr_be[l]) ? din[l*LANE_W +: LANE_W] : cells[rd_addr];
    end
endmodule

// File: rtl/psram_out.sv
module psram_out
    import psram_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_n,
    input  logic              oe_n,
    input  op_e               s1_op,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout,
    output logic              dq_oe
);
    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            dout <= '0;
        end else if (!cke_n) begin
            rd_q <= (s1_op == OP_READ);
            if (s1_op == OP_READ)
                dout <= rd_data;
        end
    end

    assign dq_oe = rd_q && !oe_n;
endmodule

// File: rtl/psram_top.sv
module psram_top
    import psram_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int LANES   = 2,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cke_n,
    input  logic                    ce_a_n,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic                    ld_n,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dq_oe
);
    localparam int DATA_W = LANES * LANE_W;

    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_be;
    logic              wr_phase;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [LANES-1:0]  wr_be;
    logic [DATA_W-1:0] rd_data;

    psram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_cmd (
        .clk(clk), .rst(rst), .cke_n(cke_n),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
        .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be)
    );

    psram_wpipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wpipe (
        .clk(clk), .rst(rst), .cke_n(cke_n),
        .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be),
        .wr_phase(wr_phase), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be)
    );

    psram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .wr_en(wr_en), .fwd_en(wr_phase),
        .wr_addr(wr_addr), .wr_be(wr_be), .din(din),
        .rd_addr(s1_addr), .rd_data(rd_data)
    );

    psram_out #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .cke_n(cke_n), .oe_n(oe_n),
        .s1_op(s1_op), .rd_data(rd_data),
        .dout(dout), .dq_oe(dq_oe)
    );
endmodule

// File: rtl/psram_chk.sv
module psram_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              cke_n,
    input logic              ce_a_n,
    input logic              ce_b,
    input logic              ce_c_n,
    input logic              ld_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dout,
    input logic              dq_oe,
    input logic              wr_phase
);
    logic sel;
    assign sel = !ce_a_n && ce_b && !ce_c_n;

    AST_WR_PHASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        wr_phase |-> !dq_oe); // R6

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> $stable(dout)); // R5

    AST_DESEL_DROP: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && !ld_n && !sel) ##1 !cke_n |=> !dq_oe); // R7

    AST_READ_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && !ld_n && sel && we_n) ##1 !cke_n |=> (dq_oe == !oe_n)); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !dq_oe); // R11
endmodule

bind psram_top psram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .cke_n(cke_n),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .ld_n(ld_n), .we_n(we_n), .oe_n(oe_n),
    .dout(dout), .dq_oe(dq_oe), .wr_phase(wr_phase)
);

// File: tb/psram_top_bench.sv
module psram_top_bench;
    localparam int PERIOD = 10;
    localparam logic [2:0] SEL  = 3'b010;  // {ce_a_n, ce_b, ce_c_n}
    localparam logic [2:0] DSEL = 3'b110;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke_n = 1'b0;
    logic        ld_n = 1'b0;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b0;
    logic [2:0]  ce = DSEL;
    logic [1:0]  bw_n = 2'b11;
    logic [3:0]  addr = '0;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic        dq_oe;

    int n_cmp = 0;
    int n_bad = 0;
    logic [17:0] model [16];

    always #(PERIOD/2) clk = ~clk;

    psram_top u_psram_top (
        .clk(clk), .rst(rst), .cke_n(cke_n),
        .ce_a_n(ce[2]), .ce_b(ce[1]), .ce_c_n(ce[0]),
        .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe)
    );

    function automatic logic [17:0] pat(input int a);
        return 18'((a * 12345 + 777) ^ (a << 9));
    endfunction

    function automatic logic [17:0] merge(input logic [17:0] old, input logic [17:0] nw,
                                          input logic [1:0] b);
        logic [17:0] r = old;
        if (!b[0]) r[8:0]  = nw[8:0];
        if (!b[1]) r[17:9] = nw[17:9];
        return r;
    endfunction

    task automatic tick(input logic k, input logic [2:0] c, input logic l, input logic w,
                        input logic [1:0] b, input logic [3:0] a, input logic [17:0] d);
        cke_n = k; ce = c; ld_n = l; we_n = w; bw_n = b; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] b, input logic [17:0] d);
        tick(1'b0, SEL, 1'b0, 1'b0, b, a, d);
    endtask
    task automatic rd(input logic [3:0] a, input logic [17:0] d);
        tick(1'b0, SEL, 1'b0, 1'b1, 2'b11, a, d);
    endtask
    task automatic nop(input logic [17:0] d);
        tick(1'b0, DSEL, 1'b0, 1'b1, 2'b11, 4'h0, d);
    endtask
    task automatic stl(input logic [17:0] d);
        tick(1'b1, SEL, 1'b0, 1'b0, 2'b00, 4'hF, d);
    endtask
    task automatic adv(input logic [1:0] b, input logic w, input logic [17:0] d);
        tick(1'b0, 3'b111, 1'b1, w, b, 4'h5, d);
    endtask

    task automatic chk(input string tag, input logic [17:0] got, input logic [17:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [17:0] d1, d2, d3, da, db, dc, dd;
        @(negedge clk);
        rst = 1'b1;
        nop('0);
        nop('0);
        rst = 1'b0;
        // R11: reset state
        chk("R11 dq_oe after reset", 18'(dq_oe), 18'd0);
        chk("R11 dout after reset", dout, 18'd0);

        // R1 R2 R3: full sweep, write data two edges behind its address
        for (int i = 0; i < 18; i++) begin
            if (i < 16) wr(4'(i), 2'b00, (i >= 2) ? pat(i - 2) : 18'h0);
            else        nop(pat(i - 2));
        end
        for (int i = 0; i < 16; i++) model[i] = pat(i);
        for (int i = 0; i < 17; i++) begin
            if (i < 16) rd(4'(i), 18'h3FFFF);
            else        nop(18'h3FFFF);
            if (i >= 1) begin
                chk("R2 sweep read data", dout, model[i - 1]);
                chk("R2 sweep drive", 18'(dq_oe), 18'd1);
            end
        end

        // R1: each non-selecting chip-enable pattern blocks the write
        for (int k = 0; k < 3; k++) begin
            logic [2:0] bad = (k == 0) ? 3'b110 : (k == 1) ? 3'b000 : 3'b011;
            tick(1'b0, bad, 1'b0, 1'b0, 2'b00, 4'h0, 18'h0);
            nop(18'h0);
            nop(18'h15555);
            rd(4'h0, 18'h0);
            nop(18'h0);
            chk("R1 deselected write ignored", dout, model[0]);
        end

        // R4: lane masks, lane i = bits [9i+8:9i]
        d1 = 18'h2A5A5; d2 = 18'h1F0F0; d3 = 18'h3C3C3;
        wr(4'd3, 2'b10, 18'h0); nop(18'h0); nop(d1);
        wr(4'd4, 2'b11, 18'h0); nop(18'h0); nop(d2);
        wr(4'd5, 2'b01, 18'h0); nop(18'h0); nop(d3);
        model[3] = merge(model[3], d1, 2'b10);
        model[5] = merge(model[5], d3, 2'b01);
        rd(4'd3, 18'h0);
        rd(4'd4, 18'h0);
        chk("R4 lane0 only", dout, model[3]);
        rd(4'd5, 18'h0);
        chk("R4 no lanes selected", dout, model[4]);
        nop(18'h0);
        chk("R4 lane1 only", dout, model[5]);

        // R2 R3 R6: alternate write/read every cycle
        d1 = 18'h12345; d2 = 18'h0BEEF;
        wr(4'd7, 2'b00, 18'h0);
        rd(4'd8, 18'h0);
        chk("R6 write phase undriven", 18'(dq_oe), 18'd0);
        wr(4'd9, 2'b00, d1);
        model[7] = d1;
        chk("R2 read between writes", dout, model[8]);
        chk("R2 read drive", 18'(dq_oe), 18'd1);
        rd(4'd7, 18'h0);
        chk("R6 write phase undriven 2", 18'(dq_oe), 18'd0);
        nop(d2);
        model[9] = d2;
        chk("R3 data stored two edges later", dout, model[7]);
        rd(4'd9, 18'h0);
        nop(18'h0);
        chk("R3 second alternating write", dout, model[9]);

        // R9: read during the masked write's data phase
        d1 = 18'h2F00F;
        wr(4'd6, 2'b01, 18'h0);
        rd(4'd6, 18'h0);
        nop(d1);
        model[6] = merge(model[6], d1, 2'b01);
        chk("R9 forwarded merge", dout, model[6]);
        rd(4'd6, 18'h0);
        nop(18'h0);
        chk("R9 array after merge", dout, model[6]);

        // R5: stall between command and data
        d1 = 18'h0A0A0;
        wr(4'd11, 2'b00, 18'h0);
        stl(18'h11111);
        nop(18'h22222);
        nop(d1);
        model[11] = d1;
        rd(4'd11, 18'h0);
        nop(18'h0);
        chk("R5 stall not counted", dout, model[11]);
        rd(4'd8, 18'h0);
        stl(18'h0);
        chk("R5 dout held across stall", dout, model[11]);
        nop(18'h0);
        chk("R5 read resumes after stall", dout, model[8]);

        // R8: dummy read, then asynchronous enable
        oe_n = 1'b1;
        rd(4'd8, 18'h0);
        nop(18'h0);
        chk("R8 dummy read undriven", 18'(dq_oe), 18'd0);
        oe_n = 1'b0;
        #1;
        chk("R8 oe_n drives at once", 18'(dq_oe), 18'd1);
        chk("R8 dummy read data", dout, model[8]);

        // R7: pipelined deselect and advance while deselected
        rd(4'd8, 18'h0);
        tick(1'b0, 3'b000, 1'b0, 1'b1, 2'b11, 4'h0, 18'h0);
        chk("R7 still driving after deselect edge", 18'(dq_oe), 18'd1);
        nop(18'h0);
        chk("R7 undriven after following edge", 18'(dq_oe), 18'd0);
        adv(2'b11, 1'b1, 18'h0);
        adv(2'b11, 1'b1, 18'h0);
        chk("R7 advance keeps deselect", 18'(dq_oe), 18'd0);

        // R10: linear wrapped burst from 14, chip enables and we_n ignored on advance
        da = 18'h11AA1; db = 18'h22BB2; dc = 18'h33CC3; dd = 18'h04DD4;
        wr(4'd14, 2'b00, 18'h0);
        adv(2'b00, 1'b1, 18'h0);
        adv(2'b10, 1'b1, da);
        adv(2'b00, 1'b1, db);
        nop(dc);
        nop(dd);
        model[14] = da;
        model[15] = db;
        model[12] = merge(model[12], dc, 2'b10);
        model[13] = dd;
        rd(4'd14, 18'h0);
        adv(2'b11, 1'b0, 18'h0);
        chk("R10 burst beat 0", dout, model[14]);
        adv(2'b11, 1'b0, 18'h0);
        chk("R10 burst beat 1", dout, model[15]);
        adv(2'b11, 1'b0, 18'h0);
        chk("R10 burst wrap beat 2", dout, model[12]);
        nop(18'h0);
        chk("R10 burst beat 3", dout, model[13]);

        // R11: reset drops a write in flight
        wr(4'd2, 2'b00, 18'h0);
        rst = 1'b1;
        nop(18'h3AAAA);
        rst = 1'b0;
        chk("R11 undriven after mid-run reset", 18'(dq_oe), 18'd0);
        nop(18'h35555);
        nop(18'h3AAAA);
        rd(4'd2, 18'h0);
        nop(18'h0);
        chk("R11 pending write dropped", dout, model[2]);

        finish_run();
    end
endmodule